// File: doc/BRIEF.md
# Reciprocal Estimate Unit

This block returns a coarse reciprocal of its operand, accurate to about eight bits. It serves as the seed for a later iterative divide or refinement step. In floating-point mode the operand is a single-precision number. In unsigned mode the operand is a 32-bit fixed-point fraction in [0, 1), and the result is a fraction with its top bit set. Each operation takes one clock. Four exception flags collect events across operations until the next reset.

The estimate comes from a 256-entry table that is computed while the design elaborates. Eight operand bits select an interval, and the table returns the reciprocal of that interval's midpoint, rounded to a 1/256 grid. The floating-point path also handles the special cases in front of the table: NaNs, zeros, subnormals, infinities and operands too large to invert. It then builds the result exponent with a fixed subtraction.

Top module: `recip_est`

## Requirements
- R1: `valid_out` equals `valid_in` of the previous clock. An accepted operation (`valid_in`=1) updates `result` on the next clock. While `valid_in` is 0, `result` holds its last value.
- R2: In float mode (`mode_uint`=0), an operand with exponent field 0xFF and a non-zero fraction gives 0x7FC00000. `flag_invalid` is set when the fraction bit 22 of that operand is 0 (a signalling NaN).
- R3: In float mode, +0 or -0 gives an infinity with the operand's sign (0x7F800000 or 0xFF800000) and sets `flag_divzero`.
- R4: In float mode, an operand with exponent field 0 and a non-zero fraction (a subnormal) gives an infinity with the operand's sign and sets `flag_overflow`.
- R5: In float mode, an infinity gives a zero with the operand's sign and sets no flag.
- R6: In float mode, an operand with exponent field 253 or 254 (magnitude at least 2^126) gives a zero with the operand's sign and sets `flag_underflow`.
- R7: In float mode, a normal operand with exponent field e in 1..252 gives sign = operand sign, exponent = 253 − e, fraction bits [22:15] = T(k) and fraction bits [14:0] = 0. Here k is operand bits [22:15], and T(k) = round(2^18 / (2·(256+k)+1)) − 256.
- R8: In unsigned mode (`mode_uint`=1), an operand with bit 31 clear gives 0xFFFFFFFF. Otherwise the result is {1, T(operand[30:23]), 23 zero bits}.
- R9: An operation in unsigned mode changes no flag.
- R10: Flags are sticky. Once set, a flag stays set until reset. Reset clears `valid_out`, `result` and all flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_in | input | 1 | Operation strobe |
| mode_uint | input | 1 | 0 = single-precision float, 1 = unsigned fixed-point |
| operand | input | 32 | Operand |
| valid_out | output | 1 | Result strobe, one clock after `valid_in` |
| result | output | 32 | Estimate |
| flag_invalid | output | 1 | Sticky: signalling NaN seen |
| flag_divzero | output | 1 | Sticky: zero operand seen |
| flag_overflow | output | 1 | Sticky: subnormal operand seen |
| flag_underflow | output | 1 | Sticky: operand too large to invert |

## Verification
The hardest case to reach from the ports is the stickiness of the flags. A flag set by one operation must survive a later flagless operation of the other mode. It must also survive a quiet NaN and idle cycles, and only a reset may clear it. The stimulus therefore raises each flag and follows it with unsigned-mode operations, quiet NaNs and gaps in `valid_in`. It then asserts reset in the middle of the run and raises the flags again. Every entry of the table is reached through sweeps of both modes over all 256 index values, with exponents and signs that vary. The exponent boundaries at 0, 1, 252, 253, 254 and 255 are driven directly.

// File: rtl/recip_est_pkg.sv
// Package for the reciprocal estimate unit.
// Holds the index width, the flag type and the constant function
// that computes one table entry during elaboration.
package recip_est_pkg;

    localparam int RCP_IDX_W = 8;

    typedef struct packed {
        logic inv;
        logic dz;
        logic ovf;
        logic unf;
    } rcp_flags_t;

    // Entry k: reciprocal of the midpoint of interval (2^w + k)/2^(w+1),
    // scaled by 2^w and rounded to nearest, with the leading one removed.
    function automatic logic [15:0] rcp_entry(input int w, input int k);
        longint num;
        longint den;
        longint s;
        num = longint'(1) << (2 * w + 3);
        den = 2 * ((longint'(1) << w) + k) + 1;
        s   = (num / den + 1) / 2;
        return 16'(s - (longint'(1) << w));
    endfunction

endpackage

// File: rtl/recip_lut.sv
// Reciprocal lookup table.
// Assumes the index selects an interval of a mantissa in [0.5, 1).
// Returns the fraction bits of the estimate; the implied one is not stored.
module recip_lut
    import recip_est_pkg::*;
#(
    parameter int IDX_W = RCP_IDX_W
) (
    input  logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] frac
);
    localparam int DEPTH = 1 << IDX_W;

    logic [IDX_W-1:0] tbl [DEPTH];

    // Fill the table from the constant function
    for (genvar k = 0; k < DEPTH; k++) begin : g_tbl
        localparam logic [15:0] ENTRY = rcp_entry(IDX_W, k);
        assign tbl[k] = ENTRY[IDX_W-1:0];
    end

    // Table read
    always_comb frac = tbl[idx];

endmodule

// File: rtl/recip_fp_path.sv
// Single-precision path of the reciprocal estimate.
// Sorts the operand into its special classes, builds the normal result
// from the table fraction, and reports the exception events of this operation.
// Assumes frac was looked up with operand bits [22:23-IDX_W].
module recip_fp_path
    import recip_est_pkg::*;
#(
    parameter int IDX_W = RCP_IDX_W
) (
    input  logic [31:0]      op,
    input  logic [IDX_W-1:0] frac,
    output logic [31:0]      res,
    output rcp_flags_t       flg
);
    localparam int          MANT_W   = 23;
    localparam int          PAD_W    = MANT_W - IDX_W;
    localparam logic [7:0]  EXP_MAX  = 8'hFF;
    localparam logic [7:0]  EXP_BASE = 8'd253;
    localparam logic [31:0] QNAN     = 32'h7FC0_0000;

    logic              sgn;
    logic [7:0]        ex;
    logic [MANT_W-1:0] man;

    assign sgn = op[31];
    assign ex  = op[30:23];
    assign man = op[22:0];

    // Pick the result and this operation's flags by operand class
    always_comb begin
        flg = '0;
        res = {sgn, 8'(EXP_BASE - ex), frac, {PAD_W{1'b0}}};
        if (ex == EXP_MAX && man != '0) begin
            res     = QNAN;
            flg.inv = ~man[MANT_W-1];
        end else if (ex == EXP_MAX) begin
            res = {sgn, 31'd0};
        end else if (ex == 8'd0) begin
            res = {sgn, EXP_MAX, {MANT_W{1'b0}}};
            if (man == '0) flg.dz  = 1'b1;
            else           flg.ovf = 1'b1;
        end else if (ex >= EXP_BASE) begin
            res     = {sgn, 31'd0};
            flg.unf = 1'b1;
        end
    end

endmodule

// File: rtl/recip_uint_path.sv
// Unsigned fixed-point path of the reciprocal estimate.
// Assumes frac was looked up with operand bits [30:31-IDX_W].
// An operand below one half saturates to all ones.
module recip_uint_path #(
    parameter int IDX_W = 8
) (
    input  logic             op_msb,
    input  logic [IDX_W-1:0] frac,
    output logic [31:0]      res
);
    localparam int PAD_W = 31 - IDX_W;

    // Saturate or place the estimate below a forced top bit
    always_comb begin
        if (!op_msb) res = 32'hFFFF_FFFF;
        else         res = {1'b1, frac, {PAD_W{1'b0}}};
    end

endmodule

// File: rtl/recip_est.sv
// Reciprocal estimate unit, top level.
// Selects the table index by mode and shares one table between both paths.
// Registers the result and the valid strobe with one clock of latency, and
// accumulates sticky flags. Synchronous active-low reset.
module recip_est
    import recip_est_pkg::*;
#(
    parameter int IDX_W = RCP_IDX_W
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        valid_in,
    input  logic        mode_uint,
    input  logic [31:0] operand,
    output logic        valid_out,
    output logic [31:0] result,
    output logic        flag_invalid,
    output logic        flag_divzero,
    output logic        flag_overflow,
    output logic        flag_underflow
);
    logic [IDX_W-1:0] lut_idx;
    logic [IDX_W-1:0] lut_frac;
    logic [31:0]      fp_res;
    logic [31:0]      u_res;
    rcp_flags_t       fp_flg;
    rcp_flags_t       sticky_q;

    // Index: fraction bits below the hidden one (float) or below bit 31 (unsigned)
    always_comb begin
        if (mode_uint) lut_idx = operand[30:31-IDX_W];
        else           lut_idx = operand[22:23-IDX_W];
    end

    recip_lut #(.IDX_W(IDX_W)) u_lut (
        .idx  (lut_idx),
        .frac (lut_frac)
    );

    recip_fp_path #(.IDX_W(IDX_W)) u_fp (
        .op   (operand),
        .frac (lut_frac),
        .res  (fp_res),
        .flg  (fp_flg)
    );

    recip_uint_path #(.IDX_W(IDX_W)) u_uint (
        .op_msb (operand[31]),
        .frac   (lut_frac),
        .res    (u_res)
    );

    // Output register, valid pipeline and sticky flag accumulation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
            result    <= '0;
            sticky_q  <= '0;
        end else begin
            valid_out <= valid_in;
            if (valid_in) begin
                result <= mode_uint ? u_res : fp_res;
                if (!mode_uint) sticky_q <= sticky_q | fp_flg;
            end
        end
    end

    assign flag_invalid   = sticky_q.inv;
    assign flag_divzero   = sticky_q.dz;
    assign flag_overflow  = sticky_q.ovf;
    assign flag_underflow = sticky_q.unf;

endmodule

// File: rtl/recip_est_chk.sv
// Port-level assertions for the reciprocal estimate unit, bound to the top.
module recip_est_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        valid_in,
    input logic        mode_uint,
    input logic [31:0] operand,
    input logic        valid_out,
    input logic [31:0] result,
    input logic        flag_invalid,
    input logic        flag_divzero,
    input logic        flag_overflow,
    input logic        flag_underflow
);
    // R1
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out == $past(valid_in));

    // R1
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(result));

    // R2
    nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !mode_uint && operand[30:23] == 8'hFF && operand[22:0] != 23'd0)
        |=> result == 32'h7FC0_0000);

    // R3
    divzero_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_divzero) |-> valid_out && result[30:0] == 31'h7F80_0000);

    // R6
    underflow_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_underflow) |-> valid_out && result[30:0] == 31'd0);

    // R8
    uint_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && mode_uint && !operand[31]) |=> result == 32'hFFFF_FFFF);

    // R10
    invalid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flag_invalid) |-> flag_invalid);

    // R10
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flag_overflow) |-> flag_overflow);

    // R9
    uint_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && mode_uint) |=> $stable({flag_invalid, flag_divzero,
                                             flag_overflow, flag_underflow}));

endmodule

bind recip_est recip_est_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .valid_in       (valid_in),
    .mode_uint      (mode_uint),
    .operand        (operand),
    .valid_out      (valid_out),
    .result         (result),
    .flag_invalid   (flag_invalid),
    .flag_divzero   (flag_divzero),
    .flag_overflow  (flag_overflow),
    .flag_underflow (flag_underflow)
);

// File: tb/recip_est_tb.sv
module recip_est_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic        mode_uint = 1'b0;
    logic [31:0] operand = '0;
    logic        valid_out;
    logic [31:0] result;
    logic        flag_invalid, flag_divzero, flag_overflow, flag_underflow;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // model state
    logic [31:0] m_result = '0;
    logic [3:0]  m_flags  = '0;   // {inv, dz, ovf, unf}
    logic        m_valid  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    recip_est u_dut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .mode_uint(mode_uint),
        .operand(operand), .valid_out(valid_out), .result(result),
        .flag_invalid(flag_invalid), .flag_divzero(flag_divzero),
        .flag_overflow(flag_overflow), .flag_underflow(flag_underflow)
    );

    function automatic int ref_t(input int k);
        real x;
        x = 262144.0 / real'(2 * (256 + k) + 1);
        return $rtoi(x + 0.5) - 256;
    endfunction

    // Behavioural reference: result and per-operation flags
    task automatic ref_op(input bit um, input logic [31:0] op,
                          output logic [31:0] r, output logic [3:0] f);
        int e, t;
        f = 4'b0000;
        e = int'(op[30:23]);
        if (um) begin
            t = ref_t(int'(op[30:23]));
            r = op[31] ? (32'h8000_0000 | (32'(t) << 23)) : 32'hFFFF_FFFF;
        end else if (e == 255 && op[22:0] != 0) begin
            r = 32'h7FC0_0000;
            if (!op[22]) f[3] = 1'b1;
        end else if (e == 255) begin
            r = {op[31], 31'd0};
        end else if (e == 0) begin
            r = {op[31], 31'h7F80_0000};
            if (op[22:0] == 0) f[2] = 1'b1; else f[1] = 1'b1;
        end else if (e >= 253) begin
            r = {op[31], 31'd0};
            f[0] = 1'b1;
        end else begin
            t = ref_t(int'(op[22:15]));
            r = {op[31], 8'(253 - e), 8'(t), 15'd0};
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp_v);
        end
    endtask

    // One clock: drive at negedge, compare at the following negedge
    task automatic step(input string req, input bit v, input bit um, input logic [31:0] op);
        logic [31:0] r;
        logic [3:0]  f;
        valid_in  = v;
        mode_uint = um;
        operand   = op;
        ref_op(um, op, r, f);
        m_valid = v;
        if (v) begin
            m_result = r;
            if (!um) m_flags = m_flags | f;
        end
        @(negedge clk);
        check({req, " R1 valid"}, {31'd0, valid_out}, {31'd0, m_valid});
        check({req, " result"}, result, m_result);
        check({req, " R10 flags"},
              {28'd0, flag_invalid, flag_divzero, flag_overflow, flag_underflow},
              {28'd0, m_flags});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        valid_in = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_result = '0; m_flags = '0; m_valid = 1'b0;
        check("R10 reset valid", {31'd0, valid_out}, 32'd0);
        check("R10 reset result", result, 32'd0);
        check("R10 reset flags",
              {28'd0, flag_invalid, flag_divzero, flag_overflow, flag_underflow}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R7 known points: 1.0 and 2.0
        step("R7 one", 1, 0, 32'h3F80_0000);
        check("R7 one exact", result, 32'h3F7F_8000);
        step("R7 two", 1, 0, 32'h4000_0000);
        check("R7 two exact", result, 32'h3EFF_8000);
        step("R7 exp252", 1, 0, 32'hFE7F_FFFF);
        step("R7 exp1", 1, 0, 32'h0080_0000);
        // R1 hold while idle
        step("R1 idle", 0, 0, 32'h7F80_0001);
        step("R1 idle2", 0, 1, 32'h0000_0000);
        // R2 quiet NaN leaves invalid clear, signalling sets it
        step("R2 qnan", 1, 0, 32'hFFC1_2345);
        step("R2 snan", 1, 0, 32'h7F80_0001);
        // R9 unsigned ops keep flags
        step("R9 uint", 1, 1, 32'h8000_0000);
        step("R8 uint one", 1, 1, 32'h8000_0000);
        check("R8 uint exact", result, 32'hFF80_0000);
        step("R8 uint small", 1, 1, 32'h7FFF_FFFF);
        step("R3 pzero", 1, 0, 32'h0000_0000);
        step("R3 nzero", 1, 0, 32'h8000_0000);
        step("R4 subn", 1, 0, 32'h8000_0001);
        step("R5 pinf", 1, 0, 32'h7F80_0000);
        step("R5 ninf", 1, 0, 32'hFF80_0000);
        step("R6 exp253", 1, 0, 32'h7E80_0000);
        step("R6 exp254", 1, 0, 32'hFF7F_FFFF);
        step("R9 uint after flags", 1, 1, 32'hC123_4567);
        // Reset mid-run clears flags, then raise one at a time
        do_reset();
        step("R6 alone", 1, 0, 32'h7F00_0000);
        step("R2 qnan alone", 1, 0, 32'h7FFF_FFFF);
        step("R4 alone", 1, 0, 32'h0040_0000);
        // Sweeps over every table entry
        for (int i = 0; i < 256; i++) begin
            logic [31:0] op;
            op = {i[0], 8'(1 + (i * 37) % 252), 8'(i), 15'(i * 131)};
            step("R7 sweep", 1, 0, op);
        end
        for (int i = 0; i < 256; i++) begin
            logic [31:0] op;
            op = {1'b1, 8'(i), 23'(i * 9973)};
            step("R8 sweep", 1, 1, op);
            if (i % 17 == 0) step("R1 gap", 0, 0, 32'h0);
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule